// File: doc/BRIEF.md
# Adaptive Cache Bypass Tracker

This block decides, for every cache miss, whether the incoming line should skip allocation and leave the chosen victim in place. It also learns whether skipping pays off. The decision is random: the low bits of a random word supplied by the caller are compared against a threshold. That threshold comes from a single shared probability code, which the block raises or lowers as evidence comes in.

Each set keeps one small tracking record. After a real bypass, the record holds the low tag bits of the line that was not allocated, plus the way of the victim that was kept. Later references to that set settle the question. Touching the kept way first means the bypass was worth it. Asking again for the skipped tag first means it was not.

Misses that are allocated normally can also be sampled as virtual bypasses. In that case the record holds the evicted tag and the newly filled way, and the verdict is read in the opposite sense. This keeps learning alive even when the probability has fallen to zero.

Cache events arrive on a valid/ready request stream, and each accepted event yields exactly one response carrying the bypass decision.
- An event is taken on a clock edge where `req_valid` and `req_ready` are both high.
- `req_ready` is low only while an earlier response is waiting and `rsp_ready` is low.
- A waiting response holds its value until it is taken.

Top module: `bypass_tracker`

## Requirements
- R1: After reset, `prob_code` equals INIT_CODE (default 7), every set's record is empty, and `rsp_valid` is low.
- R2: The probability code works as follows.
  - Code 0 means never bypass. Code c from 1 to 13 means probability 2^(c-13).
  - A miss bypasses exactly when `req_rnd[11:0]` is below the threshold. The threshold is 0 for code 0 and 2^(c-1) otherwise, so code 13 bypasses every miss.
  - A hit never bypasses.
- R3: A real bypass in a set with an empty record starts a real record. The record stores `req_tag[15:0]` and the victim way `req_way`.
- R4: A miss that is not bypassed starts a virtual record when the set's record is empty and `req_rnd[15:12]` is zero (probability 1/16). The record stores `req_vtag[15:0]` (the evicted tag) and the filled way `req_way`.
- R5: For a real record, the first event that settles it gives the verdict.
  - A hit on the recorded way is an effective verdict.
  - An event whose `req_tag[15:0]` equals the stored tag is an ineffective verdict.
  - If one event does both, the way hit wins.
  - Either verdict empties the record.
- R6: For a virtual record, the sense is reversed. A hit on the recorded way is ineffective, and a stored-tag match is effective. The record is emptied the same way.
- R7: An effective verdict raises the code: 0 becomes MIN_CODE (default 5), c becomes c+1, and 13 stays 13.
- R8: An ineffective verdict lowers the code: MIN_CODE becomes 0, c becomes c-1, and 0 stays 0.
- R9: A non-bypassed miss whose victim way equals the recorded way empties the record with no verdict. A bypassed miss leaves the record alone.
- R10: No new record is started in a set whose record was non-empty when the event arrived. This includes an event that empties the record.
- R11: Records of different sets are independent. An event touches only the record of `req_set`.
- R12: Each accepted event produces one response in the next cycle.
  - `req_ready` equals `!rsp_valid || rsp_ready`.
  - A stalled response keeps `rsp_bypass` stable.
  - `prob_code` changes only on the edge that accepts an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Event offered |
| req_ready | output | 1 | Event can be taken |
| req_set | input | SET_W | Set index of the event |
| req_hit | input | 1 | 1 = hit, 0 = miss |
| req_way | input | WAY_W | Hit way, or the victim way on a miss |
| req_tag | input | TAG_W | Tag referenced (incoming tag on a miss) |
| req_vtag | input | TAG_W | Tag of the victim on a miss |
| req_rnd | input | RND_W | Random word: [LVL_BITS-1:0] level, upper bits virtual sample |
| rsp_valid | output | 1 | Decision available |
| rsp_ready | input | 1 | Decision taken |
| rsp_bypass | output | 1 | 1 = do not allocate the incoming line |
| prob_code | output | 4 | Current bypass probability code |

## Verification
The bound checker checks the following on every cycle:
- the code never leaves its legal set;
- the code moves by at most one step, and only on an accepted event;
- hits never bypass;
- code 13 always bypasses and code 0 never does;
- a stalled response holds.

Only the bench's scenarios can show the learning itself. These scenarios cover:
- which tag and way a record captures;
- the reversed verdict of virtual records;
- way-hit precedence;
- eviction of the tracked way;
- a busy set refusing a second record;
- independence across sets;
- saturation at both ends of the code range.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int CODE_W = 4;

  typedef enum logic [1:0] {
    VD_NONE = 2'd0,
    VD_GOOD = 2'd1,
    VD_BAD  = 2'd2
  } verdict_e;

  function automatic logic [CODE_W-1:0] code_up(input logic [CODE_W-1:0] c,
                                                input logic [CODE_W-1:0] lo,
                                                input logic [CODE_W-1:0] top);
    if (c == '0)      return lo;
    else if (c >= top) return top;
    else              return c + 1'b1;
  endfunction

  function automatic logic [CODE_W-1:0] code_down(input logic [CODE_W-1:0] c,
                                                  input logic [CODE_W-1:0] lo);
    if (c <= lo) return '0;
    else         return c - 1'b1;
  endfunction
endpackage

// File: rtl/bt_prob_reg.sv
module bt_prob_reg
  import bt_pkg::*;
#(
  parameter int LVL_BITS  = 12,
  parameter int INIT_CODE = 7,
  parameter int MIN_CODE  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd_en,
  input  verdict_e            vd,
  output logic [CODE_W-1:0]   code,
  output logic [LVL_BITS:0]   thr
);
  localparam int TOP_CODE = LVL_BITS + 1;
  localparam logic [CODE_W-1:0] LO  = CODE_W'(MIN_CODE);
  localparam logic [CODE_W-1:0] TOP = CODE_W'(TOP_CODE);

  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= CODE_W'(INIT_CODE);
    end else if (upd_en) begin
      case (vd)
        VD_GOOD: code_q <= code_up(code_q, LO, TOP);
        VD_BAD:  code_q <= code_down(code_q, LO);
        default: code_q <= code_q;
      endcase
    end
  end

  always_comb begin
    thr = '0;
    if (code_q != '0) thr = (LVL_BITS+1)'(1) << (code_q - 1'b1);
  end

  assign code = code_q;
endmodule

// File: rtl/bt_record_bank.sv
module bt_record_bank #(
  parameter int SETS   = 16,
  parameter int PTAG_W = 16,
  parameter int WAY_W  = 4,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  rd_set,
  output logic              rd_valid,
  output logic [PTAG_W-1:0] rd_tag,
  output logic [WAY_W-1:0]  rd_way,
  output logic              rd_virt,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic              wr_valid,
  input  logic [PTAG_W-1:0] wr_tag,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic              wr_virt
);
  logic              v_a    [SETS];
  logic [PTAG_W-1:0] tag_a  [SETS];
  logic [WAY_W-1:0]  way_a  [SETS];
  logic              virt_a [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic              v_q;
    logic [PTAG_W-1:0] tag_q;
    logic [WAY_W-1:0]  way_q;
    logic              virt_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q    <= 1'b0;
        tag_q  <= '0;
        way_q  <= '0;
        virt_q <= 1'b0;
      end else if (wr_en && wr_set == SET_W'(s)) begin
        v_q <= wr_valid;
        if (wr_valid) begin
          tag_q  <= wr_tag;
          way_q  <= wr_way;
          virt_q <= wr_virt;
        end
      end
    end

    assign v_a[s]    = v_q;
    assign tag_a[s]  = tag_q;
    assign way_a[s]  = way_q;
    assign virt_a[s] = virt_q;
  end

  assign rd_valid = v_a[rd_set];
  assign rd_tag   = tag_a[rd_set];
  assign rd_way   = way_a[rd_set];
  assign rd_virt  = virt_a[rd_set];
endmodule

// File: rtl/bt_judge.sv
module bt_judge
  import bt_pkg::*;
#(
  parameter int PTAG_W    = 16,
  parameter int WAY_W     = 4,
  parameter int LVL_BITS  = 12,
  parameter int VIRT_BITS = 4,
  localparam int RND_W    = LVL_BITS + VIRT_BITS
) (
  input  logic              act,
  input  logic              rec_v,
  input  logic [PTAG_W-1:0] rec_tag,
  input  logic [WAY_W-1:0]  rec_way,
  input  logic              rec_virt,
  input  logic              req_hit,
  input  logic [WAY_W-1:0]  req_way,
  input  logic [PTAG_W-1:0] req_ptag,
  input  logic [PTAG_W-1:0] req_vptag,
  input  logic [RND_W-1:0]  rnd,
  input  logic [LVL_BITS:0] thr,
  output logic              bypass,
  output verdict_e          vd,
  output logic              wr_en,
  output logic              wr_valid,
  output logic [PTAG_W-1:0] wr_tag,
  output logic [WAY_W-1:0]  wr_way,
  output logic              wr_virt
);
  logic way_ref, tag_ref, evict_clr, sample, start_real, start_virt;
  logic [LVL_BITS-1:0]  lvl;
  logic [VIRT_BITS-1:0] vsel;

  assign lvl  = rnd[LVL_BITS-1:0];
  assign vsel = rnd[RND_W-1:LVL_BITS];

  // The way hit takes precedence over a tag match in the same event.
  assign way_ref = act && rec_v && req_hit && (req_way == rec_way);
  assign tag_ref = act && rec_v && !way_ref && (req_ptag == rec_tag);

  assign bypass  = act && !req_hit && ({1'b0, lvl} < thr);
  assign sample  = (vsel == '0);

  // The tracked way is evicted only when the incoming line is really allocated.
  assign evict_clr  = act && rec_v && !way_ref && !tag_ref && !req_hit && !bypass
                      && (req_way == rec_way);
  assign start_real = act && !rec_v && bypass;
  assign start_virt = act && !rec_v && !req_hit && !bypass && sample;

  always_comb begin
    vd = VD_NONE;
    if (way_ref)      vd = rec_virt ? VD_BAD  : VD_GOOD;
    else if (tag_ref) vd = rec_virt ? VD_GOOD : VD_BAD;
  end

  assign wr_en    = way_ref || tag_ref || evict_clr || start_real || start_virt;
  assign wr_valid = start_real || start_virt;
  assign wr_tag   = start_real ? req_ptag : req_vptag;
  assign wr_way   = req_way;
  assign wr_virt  = start_virt;
endmodule

// File: rtl/bypass_tracker.sv
module bypass_tracker
  import bt_pkg::*;
#(
  parameter int SETS      = 16,
  parameter int WAYS      = 16,
  parameter int TAG_W     = 24,
  parameter int PTAG_W    = 16,
  parameter int LVL_BITS  = 12,
  parameter int VIRT_BITS = 4,
  parameter int INIT_CODE = 7,
  parameter int MIN_CODE  = 5,
  localparam int SET_W    = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int RND_W    = LVL_BITS + VIRT_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SET_W-1:0] req_set,
  input  logic             req_hit,
  input  logic [WAY_W-1:0] req_way,
  input  logic [TAG_W-1:0] req_tag,
  input  logic [TAG_W-1:0] req_vtag,
  input  logic [RND_W-1:0] req_rnd,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_bypass,
  output logic [3:0]       prob_code
);
  logic              act;
  logic              rec_v, rec_virt;
  logic [PTAG_W-1:0] rec_tag;
  logic [WAY_W-1:0]  rec_way;
  logic [LVL_BITS:0] thr;
  logic              byp;
  verdict_e          vd;
  logic              wr_en, wr_valid, wr_virt;
  logic [PTAG_W-1:0] wr_tag;
  logic [WAY_W-1:0]  wr_way;
  logic              rsp_v_q, rsp_b_q;

  assign req_ready = !rsp_v_q || rsp_ready;
  assign act       = req_valid && req_ready;

  bt_record_bank #(.SETS(SETS), .PTAG_W(PTAG_W), .WAY_W(WAY_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .rd_set(req_set), .rd_valid(rec_v), .rd_tag(rec_tag), .rd_way(rec_way), .rd_virt(rec_virt),
    .wr_en(wr_en), .wr_set(req_set), .wr_valid(wr_valid), .wr_tag(wr_tag),
    .wr_way(wr_way), .wr_virt(wr_virt)
  );

  bt_judge #(.PTAG_W(PTAG_W), .WAY_W(WAY_W), .LVL_BITS(LVL_BITS), .VIRT_BITS(VIRT_BITS)) u_judge (
    .act(act), .rec_v(rec_v), .rec_tag(rec_tag), .rec_way(rec_way), .rec_virt(rec_virt),
    .req_hit(req_hit), .req_way(req_way),
    .req_ptag(req_tag[PTAG_W-1:0]), .req_vptag(req_vtag[PTAG_W-1:0]),
    .rnd(req_rnd), .thr(thr), .bypass(byp), .vd(vd),
    .wr_en(wr_en), .wr_valid(wr_valid), .wr_tag(wr_tag), .wr_way(wr_way), .wr_virt(wr_virt)
  );

  bt_prob_reg #(.LVL_BITS(LVL_BITS), .INIT_CODE(INIT_CODE), .MIN_CODE(MIN_CODE)) u_prob (
    .clk(clk), .rst_n(rst_n), .upd_en(act), .vd(vd), .code(prob_code), .thr(thr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_v_q <= 1'b0;
      rsp_b_q <= 1'b0;
    end else if (act) begin
      rsp_v_q <= 1'b1;
      rsp_b_q <= byp;
    end else if (rsp_ready) begin
      rsp_v_q <= 1'b0;
    end
  end

  assign rsp_valid  = rsp_v_q;
  assign rsp_bypass = rsp_b_q;
endmodule

// File: rtl/bypass_tracker_chk.sv
module bypass_tracker_chk #(
  parameter int LVL_BITS = 12,
  parameter int MIN_CODE = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_hit,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic       rsp_bypass,
  input logic [3:0] prob_code
);
  localparam logic [3:0] TOP = 4'(LVL_BITS + 1);
  localparam logic [3:0] LO  = 4'(MIN_CODE);

  logic acc;
  assign acc = req_valid && req_ready;

  // R7, R8: the code stays within its legal set
  a_r7_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (prob_code == 4'd0) || (prob_code >= LO && prob_code <= TOP));

  // R7, R8: the code moves by at most one step
  a_r8_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prob_code) |->
      (prob_code == $past(prob_code) + 4'd1) || (prob_code == $past(prob_code) - 4'd1) ||
      ($past(prob_code) == 4'd0 && prob_code == LO) ||
      ($past(prob_code) == LO && prob_code == 4'd0));

  // R12: the code changes only on an accepted event
  a_r12_code_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(prob_code));

  // R12: a stalled response holds its value
  a_r12_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_bypass));

  // R2: a hit never bypasses
  a_r2_hit_no_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_hit |=> rsp_valid && !rsp_bypass);

  // R2: the top code bypasses every miss
  a_r2_top_all: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_hit && prob_code == TOP |=> rsp_bypass);

  // R2: code zero never bypasses
  a_r2_zero_none: assert property (@(posedge clk) disable iff (!rst_n)
    acc && prob_code == 4'd0 |=> !rsp_bypass);
endmodule

bind bypass_tracker bypass_tracker_chk #(.LVL_BITS(LVL_BITS), .MIN_CODE(MIN_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_hit(req_hit),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_bypass(rsp_bypass), .prob_code(prob_code)
);

// File: tb/sim_bypass_tracker.sv
`timescale 1ns/1ps
module sim_bypass_tracker;
  localparam int SETS = 16, TAG_W = 24, PTAG_W = 16, LVL = 12, VB = 4;
  localparam int RND_W = LVL + VB;
  localparam int INIT = 7, LO = 5, TOP = 13;
  localparam logic [RND_W-1:0] R_NB = 16'hFFFF; // no bypass (below top), no sample
  localparam logic [RND_W-1:0] R_BY = 16'hF000; // bypass whenever code > 0
  localparam logic [RND_W-1:0] R_VS = 16'h0FFF; // no bypass (below top), sampled

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_hit = 1'b0, rsp_ready = 1'b1;
  logic [3:0] req_set = '0, req_way = '0;
  logic [TAG_W-1:0] req_tag = '0, req_vtag = '0;
  logic [RND_W-1:0] req_rnd = '0;
  logic req_ready, rsp_valid, rsp_bypass;
  logic [3:0] prob_code;

  always #5 clk = ~clk;

  bypass_tracker u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_set(req_set), .req_hit(req_hit), .req_way(req_way), .req_tag(req_tag),
    .req_vtag(req_vtag), .req_rnd(req_rnd), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_bypass(rsp_bypass), .prob_code(prob_code)
  );

  int total = 0, bad = 0;

  typedef struct { bit byp; int code; string rq; } item_t;
  item_t sb[$];

  // reference state, built from the requirements
  bit m_v[SETS]; bit m_virt[SETS]; int m_tag[SETS]; int m_way[SETS];
  int m_code = INIT;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int up(input int c);
    if (c == 0) return LO; else if (c >= TOP) return TOP; else return c + 1;
  endfunction
  function automatic int dn(input int c);
    if (c <= LO) return 0; else return c - 1;
  endfunction

  task automatic send(input int s, input bit hit, input int way, input int tag, input int vtag,
                      input logic [RND_W-1:0] rnd, input string rq);
    item_t it;
    int thr, good;
    bit byp, wref, tref;
    thr  = (m_code == 0) ? 0 : (1 << (m_code - 1));
    byp  = !hit && (int'(rnd[LVL-1:0]) < thr);
    wref = m_v[s] && hit && (way == m_way[s]);
    tref = m_v[s] && !wref && ((tag & 16'hFFFF) == m_tag[s]);
    good = -1;
    if (wref) good = m_virt[s] ? 0 : 1;
    else if (tref) good = m_virt[s] ? 1 : 0;
    if (good == 1) m_code = up(m_code);
    if (good == 0) m_code = dn(m_code);
    if (m_v[s]) begin
      if (wref || tref) m_v[s] = 0;
      else if (!hit && !byp && way == m_way[s]) m_v[s] = 0;
    end else if (byp) begin
      m_v[s] = 1; m_virt[s] = 0; m_tag[s] = tag & 16'hFFFF; m_way[s] = way;
    end else if (!hit && rnd[RND_W-1:LVL] == '0) begin
      m_v[s] = 1; m_virt[s] = 1; m_tag[s] = vtag & 16'hFFFF; m_way[s] = way;
    end
    it.byp = byp; it.code = m_code; it.rq = rq;
    sb.push_back(it);
    @(negedge clk);
    req_valid = 1'b1; req_set = 4'(s); req_hit = hit; req_way = 4'(way);
    req_tag = TAG_W'(tag); req_vtag = TAG_W'(vtag); req_rnd = rnd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: compares each consumed response with the scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R12 unexpected response", 1, 0);
      end else begin
        item_t it;
        it = sb.pop_front();
        chk(rsp_bypass == it.byp, {it.rq, " bypass"}, int'(rsp_bypass), int'(it.byp));
        chk(int'(prob_code) == it.code, {it.rq, " code"}, int'(prob_code), it.code);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < SETS; i++) begin m_v[i] = 0; m_virt[i] = 0; m_tag[i] = 0; m_way[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(prob_code == 4'(INIT), "R1 reset code", int'(prob_code), INIT);
    chk(!rsp_valid, "R1 reset rsp_valid", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R12 ready when idle", int'(req_ready), 1);

    // R2 threshold at code 7 is 64
    send(0, 0, 1, 'h100, 'h200, 16'hF03F, "R2 level 63 bypasses");   // record real in set0
    send(1, 0, 1, 'h100, 'h200, 16'hF040, "R2 level 64 allocates");
    send(0, 1, 9, 'h555, 0, R_BY, "R2 hit never bypasses");

    // R3 / R5 effective: hit on kept way
    send(2, 0, 3, 'hA1234, 'h0, R_BY, "R3 real bypass starts record");
    send(2, 1, 3, 'h0, 0, R_NB, "R5 hit on kept way effective R7");
    // R5 ineffective: skipped tag returns (upper bits differ, low 16 match)
    send(3, 0, 5, 'h11BEEF, 0, R_BY, "R3 record set3");
    send(3, 0, 6, 'h22BEEF, 0, R_NB, "R5 skipped tag first ineffective R8");
    // R5 way-hit precedence
    send(4, 0, 2, 'h4444, 0, R_BY, "R3 record set4");
    send(4, 1, 2, 'h4444, 0, R_NB, "R5 way hit wins over tag R7");

    // R4 / R6 virtual: hit on filled way is ineffective
    send(5, 0, 6, 'h7777, 'hCAFE, R_VS, "R4 virtual record set5");
    send(5, 1, 6, 'h1, 0, R_NB, "R6 virtual way hit ineffective");
    send(6, 0, 7, 'h7777, 'h1D00D, R_VS, "R4 virtual record set6");
    send(6, 0, 8, 'h2D00D, 0, R_NB, "R6 virtual tag match effective");

    // R9 eviction of tracked way clears record
    send(7, 0, 2, 'h3131, 0, R_BY, "R3 record set7");
    send(7, 0, 9, 'h9999, 0, R_BY, "R9 bypassed miss keeps record");
    send(7, 0, 2, 'h5151, 0, R_NB, "R9 eviction clears record");
    send(7, 1, 2, 'h0, 0, R_NB, "R9 no verdict after clear");

    // R10 busy set, R11 independence
    send(8, 0, 1, 'hAAAA, 0, R_BY, "R3 record set8");
    send(8, 0, 7, 'hBBBB, 0, R_BY, "R10 second bypass no record");
    send(9, 1, 1, 'h0, 0, R_NB, "R11 other set unaffected");
    send(8, 1, 7, 'h0, 0, R_NB, "R10 untracked way no verdict");
    send(8, 1, 1, 'hAAAA, 0, R_NB, "R10 R5 original record verdict");
    send(10, 0, 4, 'hC0C0, 'hD0D0, R_VS, "R4 virtual record set10");
    send(10, 0, 4, 'hD0D0, 'hE0E0, R_VS, "R10 verdict event starts nothing");
    send(10, 1, 4, 'h0, 0, R_NB, "R10 no record after verdict");

    // R7 saturation at top
    for (int k = 0; k < 9; k++) begin
      send(11, 0, 3, 'h600 + k, 0, R_BY, "R3 record for raise");
      send(11, 1, 3, 'h0, 0, R_NB, "R7 raise toward top");
    end
    @(negedge clk);
    chk(prob_code == 4'(TOP), "R7 saturates at 13", int'(prob_code), TOP);
    send(12, 0, 0, 'h7000, 0, R_NB, "R2 code 13 bypasses level 4095");
    send(12, 1, 9, 'h0, 0, R_NB, "R2 hit no bypass at top");

    // R8 lowering to zero and saturation
    for (int k = 0; k < 10; k++) begin
      send(13, 0, 3, 'h800 + k, 0, R_BY, "R3 record for lower");
      send(13, 0, 4, 'h800 + k, 0, R_NB, "R8 lower toward zero");
    end
    @(negedge clk);
    chk(prob_code == 4'd0, "R8 saturates at 0", int'(prob_code), 0);
    send(14, 0, 5, 'h1, 0, 16'hF000, "R2 code 0 never bypasses");
    // R7 learning resumes from zero through virtual sampling
    send(15, 0, 5, 'h2, 'h4242, 16'h0000, "R4 virtual at code 0");
    send(15, 0, 6, 'h4242, 0, R_NB, "R7 zero raises to MIN");
    @(negedge clk);
    chk(prob_code == 4'(LO), "R7 code after zero", int'(prob_code), LO);

    // R12 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    send(1, 0, 2, 'h9, 0, R_BY, "R12 stalled response");
    for (int k = 0; k < 3; k++) begin
      chk(rsp_valid && !req_ready, "R12 stall blocks request", int'(req_ready), 0);
      chk(rsp_bypass == 1'b1, "R12 stalled value held", int'(rsp_bypass), 1);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R12 all responses seen", sb.size(), 0);
    chk(!rsp_valid, "R12 idle after drain", int'(rsp_valid), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule